// File: doc/BRIEF.md
# Bus Cycle Termination Controller

This block decides when an external bus cycle ends and whether it ends well or with an error. A cycle opens when the start strobe is sampled high while the block is idle. From that moment the block watches for three things: an internal count of wait states running out, a slave's acknowledge coming in on an asynchronous active-low pin, and an asynchronous active-low error pin. It closes every cycle with exactly one single-clock pulse, either `done` or `err`.

The acknowledge pin passes through a two-stage synchronizer and an edge detector. It counts only when it has been seen negated inside the current cycle and then falls. An acknowledge left asserted from an earlier cycle therefore cannot end a new one. Acknowledge is honoured only for chip-select cycles whose region has it enabled. The wait-state count always stays armed as a fallback. The boot region, which is the default out of reset, always uses a fixed count of 15 wait states and ignores acknowledge. A cycle whose address hit no region is refused at once with an error.

Top module: `bus_term_ctrl`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `done` and `err` are low.
- R2: On a matched cycle that ends by count, `done` is high for exactly one clock, starting at the N+1-th rising edge after the edge that accepted `cyc_start`. N is the loaded wait count (0 gives the first edge).
- R3: When `cyc_boot` is high at acceptance, N is 15 whatever `ws_count` holds, and acknowledge is ignored.
- R4: When `addr_hit` is low at acceptance, `err` pulses on the accepting edge itself, and no `done` follows.
- R5: When acknowledge is usable, `ta_n` is seen high inside the cycle, and `ta_n` is then first sampled low at edge k, `done` pulses at edge k+2.
- R6: When `ta_n` is already low when the cycle starts and stays low, the cycle ends only by count.
- R7: When `cyc_sdram` or `ack_en` is low at acceptance, a falling `ta_n` has no effect and the cycle ends by count.
- R8: When `tea_n` is first sampled low at edge k during a cycle, `err` pulses at edge k+2 with no `done`. This holds even if an acknowledge would fire at that same edge.
- R9: Each accepted cycle yields exactly one of `done` or `err`, never both in the same clock. A `cyc_start` that arrives while a cycle is open is ignored.
- R10: When acknowledge is enabled but the count runs out first, `done` pulses by count and a later acknowledge adds nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | Cycle-start strobe, accepted only when idle |
| addr_hit | input | 1 | Address matched a region |
| cyc_sdram | input | 1 | Cycle targets SDRAM space (acknowledge not used) |
| cyc_boot | input | 1 | Cycle targets the boot/default region |
| ws_count | input | WS_W | Programmed wait-state count for the region |
| ack_en | input | 1 | Acknowledge termination enabled for the region |
| ta_n | input | 1 | Asynchronous active-low transfer acknowledge |
| tea_n | input | 1 | Asynchronous active-low transfer error |
| done | output | 1 | One-clock successful termination pulse |
| err | output | 1 | One-clock error termination pulse |

## Verification
Each stimulus fixes a result tick, counting the edge that accepts the start as T0. A count-terminated cycle is due at T0+N+1, and a refused address is due at T0 itself. An acknowledge or error driven just before edge T0+j+1 is due at T0+j+3, because of the two synchronizer stages plus the registered decision. The driver pushes the kind and the due tick into a queue. The monitor samples on falling edges and compares each pulse with the head of that queue. It flags any pulse that nothing expected, and any expected pulse whose tick has passed with no output.

// File: rtl/bus_term_pkg.sv
package bus_term_pkg;

  // Reset-default wait count for the boot region.
  parameter int unsigned BT_BOOT_WS = 15;

  // Region attributes latched when a cycle is accepted.
  typedef struct packed {
    logic boot;
    logic sdram;
    logic ack_en;
  } bt_region_t;

endpackage

// File: rtl/bt_sync.sv
module bt_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= {(STAGES*W){RST_VAL}};
    else     stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/bt_ack_detect.sv
module bt_ack_detect (
  input  logic clk,
  input  logic rst,
  input  logic clr,     // cycle accepted: forget earlier negation
  input  logic ta_s,    // synchronized acknowledge, active low
  output logic fire
);

  logic prev_q;
  logic seen_neg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q     <= 1'b1;
      seen_neg_q <= 1'b0;
    end else begin
      prev_q <= ta_s;
      if (clr)       seen_neg_q <= 1'b0;
      else if (ta_s) seen_neg_q <= 1'b1;
    end
  end

  // falling edge of the synchronized line, after a negation in this cycle
  assign fire = seen_neg_q & prev_q & ~ta_s;

  // R6: a freshly opened cycle cannot fire on its next edge
  a_r6_no_fire_after_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> !fire);

endmodule

// File: rtl/bt_wait_count.sv
module bt_wait_count #(
  parameter int unsigned WS_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [WS_W-1:0] load_val,
  input  logic            en,
  output logic            zero
);

  logic [WS_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                          cnt_q <= '0;
    else if (load)                    cnt_q <= load_val;
    else if (en && (cnt_q != '0))     cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R2: the loaded count is what the next cycle starts from
  a_r2_load_taken: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt_q == $past(load_val));

endmodule

// File: rtl/bus_term_ctrl.sv
module bus_term_ctrl
  import bus_term_pkg::*;
#(
  parameter int unsigned WS_W     = 4,
  parameter int unsigned BOOT_WS  = BT_BOOT_WS,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cyc_start,
  input  logic            addr_hit,
  input  logic            cyc_sdram,
  input  logic            cyc_boot,
  input  logic [WS_W-1:0] ws_count,
  input  logic            ack_en,
  input  logic            ta_n,
  input  logic            tea_n,
  output logic            done,
  output logic            err
);

  localparam logic [WS_W-1:0] BOOT_LD = WS_W'(BOOT_WS);

  logic       busy_q;
  logic       ack_ok_q;
  logic       start_acc;
  logic [1:0] pins_s;
  logic       ta_s, tea_s;
  logic       ack_fire;
  logic       cnt_zero;
  bt_region_t region;

  assign start_acc = cyc_start & ~busy_q;
  assign region    = '{boot: cyc_boot, sdram: cyc_sdram, ack_en: ack_en};

  bt_sync #(.W(2), .STAGES(SYNC_STG), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({tea_n, ta_n}),
    .q   (pins_s)
  );
  assign ta_s  = pins_s[0];
  assign tea_s = pins_s[1];

  bt_ack_detect u_ack (
    .clk  (clk),
    .rst  (rst),
    .clr  (start_acc),
    .ta_s (ta_s),
    .fire (ack_fire)
  );

  bt_wait_count #(.WS_W(WS_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (start_acc),
    .load_val (cyc_boot ? BOOT_LD : ws_count),
    .en       (busy_q),
    .zero     (cnt_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      ack_ok_q <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (start_acc) begin
        if (!addr_hit) begin
          err <= 1'b1;
        end else begin
          busy_q   <= 1'b1;
          ack_ok_q <= region.ack_en & ~region.sdram & ~region.boot;
        end
      end else if (busy_q) begin
        if (!tea_s) begin
          err    <= 1'b1;
          busy_q <= 1'b0;
        end else if ((ack_ok_q && ack_fire) || cnt_zero) begin
          done   <= 1'b1;
          busy_q <= 1'b0;
        end
      end
    end
  end

  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(done && err));

  a_r2_single_done: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_single_err: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);

  a_r4_miss_err: assert property (@(posedge clk) disable iff (rst)
    (cyc_start && !busy_q && !addr_hit) |=> (err && !done));

  a_r9_start_opens: assert property (@(posedge clk) disable iff (rst)
    (cyc_start && !busy_q && addr_hit) |=> (busy_q && !done && !err));

endmodule

// File: tb/bus_term_ctrl_bench.sv
module bus_term_ctrl_bench;

  localparam int WS_W = 4;
  localparam logic [1:0] K_DONE = 2'b10;
  localparam logic [1:0] K_ERR  = 2'b01;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cyc_start = 1'b0;
  logic            addr_hit = 1'b1;
  logic            cyc_sdram = 1'b0;
  logic            cyc_boot = 1'b0;
  logic [WS_W-1:0] ws_count = '0;
  logic            ack_en = 1'b0;
  logic            ta_n = 1'b1;
  logic            tea_n = 1'b1;
  logic            done, err;

  bus_term_ctrl #(.WS_W(WS_W)) u_bus_term_ctrl (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .addr_hit(addr_hit),
    .cyc_sdram(cyc_sdram), .cyc_boot(cyc_boot), .ws_count(ws_count),
    .ack_en(ack_en), .ta_n(ta_n), .tea_n(tea_n), .done(done), .err(err)
  );

  always #4 clk = ~clk;

  int tick = 0;
  always @(posedge clk) tick <= tick + 1;

  typedef struct {
    logic [1:0] kind;
    int         due;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   finished = 1'b0;

  task automatic expect_at(input logic [1:0] kind, input int due, input string tag);
    exp_t e;
    e.kind = kind; e.due = due; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compare pulses with the scoreboard on falling edges
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (done || err) begin
        checks++;
        if (q.size() == 0) begin
          errors++;
          $display("FAIL unexpected pulse kind=%b tick=%0d exp none (R9)", {done, err}, tick);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (e.kind !== {done, err} || e.due != tick) begin
            errors++;
            $display("FAIL %s kind=%b tick=%0d exp kind=%b tick=%0d",
                     e.tag, {done, err}, tick, e.kind, e.due);
          end
        end
      end else if (q.size() != 0 && q[0].due < tick) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        errors++;
        $display("FAIL %s kind=none tick=%0d exp kind=%b tick=%0d",
                 e.tag, tick, e.kind, e.due);
      end
    end
  end

  // open a cycle; returns the tick of the accepting edge, ends at negedge with tick==t0
  task automatic start(input logic hit, input logic sdram, input logic boot,
                       input int ws, input logic aen, output int t0);
    @(negedge clk);
    cyc_start = 1'b1; addr_hit = hit; cyc_sdram = sdram; cyc_boot = boot;
    ws_count = WS_W'(ws); ack_en = aen;
    t0 = tick + 1;
    @(negedge clk);
    cyc_start = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    ta_n = 1'b1; tea_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired tick=%0d exp all scenarios done", tick);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    int t0;
    repeat (3) @(negedge clk);
    // R1: outputs low in reset
    checks++;
    if (done !== 1'b0 || err !== 1'b0) begin
      errors++;
      $display("FAIL R1 done=%b err=%b exp 0 0", done, err);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (done !== 1'b0 || err !== 1'b0) begin
      errors++;
      $display("FAIL R1 after release done=%b err=%b exp 0 0", done, err);
    end
    repeat (2) @(negedge clk);

    // R2: count termination, N=3, acknowledge disabled
    start(1, 0, 0, 3, 0, t0);
    expect_at(K_DONE, t0 + 4, "R2 count N=3");
    drain();

    // R2: zero wait states
    start(1, 0, 0, 0, 0, t0);
    expect_at(K_DONE, t0 + 1, "R2 count N=0");
    drain();

    // R3: boot region uses 15, ignores ws_count and acknowledge
    start(1, 0, 1, 2, 1, t0);
    expect_at(K_DONE, t0 + 16, "R3 boot default 15");
    ta_n = 1'b0;
    drain();

    // R4: unmatched address errors on the accepting edge
    start(0, 0, 0, 5, 0, t0);
    expect_at(K_ERR, t0, "R4 address miss");
    drain();

    // R5: acknowledge at j=2 with N=12 ends at t0+5
    start(1, 0, 0, 12, 1, t0);
    expect_at(K_DONE, t0 + 5, "R5 acknowledge");
    repeat (2) @(negedge clk);
    ta_n = 1'b0;
    drain();

    // R6: acknowledge held low from before the start is ignored
    ta_n = 1'b0;
    repeat (3) @(negedge clk);
    start(1, 0, 0, 6, 1, t0);
    expect_at(K_DONE, t0 + 7, "R6 held acknowledge");
    drain();

    // R7: SDRAM cycle ignores acknowledge
    start(1, 1, 0, 5, 1, t0);
    expect_at(K_DONE, t0 + 6, "R7 sdram");
    ta_n = 1'b0;
    drain();

    // R7: acknowledge disabled
    start(1, 0, 0, 5, 0, t0);
    expect_at(K_DONE, t0 + 6, "R7 ack disabled");
    ta_n = 1'b0;
    drain();

    // R8: transfer error at j=1
    start(1, 0, 0, 10, 0, t0);
    expect_at(K_ERR, t0 + 4, "R8 transfer error");
    @(negedge clk);
    tea_n = 1'b0;
    drain();

    // R8: error and acknowledge together, error wins
    start(1, 0, 0, 10, 1, t0);
    expect_at(K_ERR, t0 + 4, "R8 error over ack");
    @(negedge clk);
    tea_n = 1'b0; ta_n = 1'b0;
    drain();

    // R9: a second start while busy is ignored
    start(1, 0, 0, 4, 0, t0);
    expect_at(K_DONE, t0 + 5, "R9 start while busy");
    @(negedge clk);
    cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0;
    drain();
    repeat (12) @(negedge clk);

    // R10: count runs out before a late acknowledge
    start(1, 0, 0, 3, 1, t0);
    expect_at(K_DONE, t0 + 4, "R10 count before ack");
    repeat (5) @(negedge clk);
    ta_n = 1'b0;
    repeat (6) @(negedge clk);
    drain();
    repeat (6) @(negedge clk);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule